// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor

This block watches a serial receive line, one bit for each cycle in which the bit-enable input is high, and keeps a loss-of-signal alarm for it. The alarm rises once a long unbroken run of zero bits has come in. It falls again only when a whole span of bits passes in which no short run of zeros appears. Because the two thresholds differ, a marginal line cannot make the alarm flicker.

Every rise and every fall of the alarm sets a sticky change flag. The host clears the flag by reading the event register. The flag drives an active-high interrupt output through an enable input. The flag itself latches whether or not the enable is set. A single read strobe and a one-bit register select stand in for the host bus. Select 0 gives the live register, which holds the current alarm level. Select 1 gives the event register, which holds the change flag.

Top module: `los_monitor`

## Requirements
- R1: The synchronous active-low reset clears the zero-run count, the clearing-window count, the alarm and the change flag. After reset both registers read 0x00 and the interrupt is low.
- R2: The alarm rises on the edge that samples the 32nd consecutive zero bit. After 31 zeros followed by a one it stays low.
- R3: While the alarm is high, it falls on the edge that completes a 32-bit window containing no run of four consecutive zeros.
- R4: While the alarm is high, the fourth zero of any zero run, and every further zero of that run, resets the clearing window to empty. Counting starts again from the next bit.
- R5: The change flag is set to 1 both when the alarm rises and when it falls.
- R6: A read strobe with select 1 clears the change flag on that edge. A read strobe with select 0 leaves the flag unchanged.
- R7: If an alarm change and a clearing read of the event register fall on the same edge, the flag ends at 1.
- R8: The interrupt output equals the change flag ANDed with the interrupt-enable input. The flag latches even while the enable is low.
- R9: On cycles with the bit enable low, the line input is ignored. Neither the zero-run count nor the alarm moves.
- R10: The read data is combinational from the select. Select 0 gives the alarm level at bit 6. Select 1 gives the change flag at bit 1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Marks a cycle that carries a line bit |
| rx_bit | input | 1 | Received line bit |
| irq_en | input | 1 | Interrupt enable |
| rd_stb | input | 1 | Host read strobe |
| rd_sel | input | 1 | Register select: 0 live, 1 event |
| rd_data | output | 8 | Read data of the selected register |
| los_irq | output | 1 | Interrupt, active high |

## Verification
An alarm change and a host read of the event register can land on the same edge. The bench provokes this by holding the read strobe, with select 1, on exactly the cycle that carries the 32nd zero of a run. That run has been split by a long stretch with the bit enable low. The scoreboard expects the event register to show the flag still set on the following cycle and on the one after, with no further read. On every cycle the bench compares the whole read byte and the interrupt against its own model, so a lost event or a stale clear shows up at once.

// File: rtl/los_pkg.sv
// Package: shared constants and register select type for the LOS monitor.
// Assumes an 8-bit host read path.
package los_pkg;
    localparam int DATA_W      = 8;
    localparam int LIVE_LOS_BIT  = 6;
    localparam int EVENT_CHG_BIT = 1;

    typedef enum logic {
        SEL_LIVE  = 1'b0,
        SEL_EVENT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/los_zero_run.sv
// Module: counts consecutive zero bits on the line, saturating at RUN_SAT.
// Assumes bits are valid only when bit_en is high; a one clears the count.
module los_zero_run #(
    parameter int RUN_SAT = 32,
    localparam int W = $clog2(RUN_SAT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         rx_bit,
    output logic [W-1:0] zrun
);
    localparam logic [W-1:0] SAT_V = W'(RUN_SAT);

    // Track length of the current zero run on each enabled bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun <= '0;
        end else if (bit_en) begin
            if (rx_bit)
                zrun <= '0;
            else if (zrun != SAT_V)
                zrun <= zrun + 1'b1;
        end
    end

    p_sat_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        zrun <= SAT_V);
    p_idle_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(zrun));
endmodule

// File: rtl/los_alarm.sv
// Module: alarm state with separate declare and clear criteria.
// Declares when the incoming bit is the DECL_LEN-th zero in a row; clears
// after CLR_SPAN enabled bits with no run of CLR_RUN zeros. Emits a
// one-cycle change strobe on the edge-deciding cycle.
module los_alarm #(
    parameter int DECL_LEN = 32,
    parameter int CLR_SPAN = 32,
    parameter int CLR_RUN  = 4,
    localparam int ZW = $clog2(DECL_LEN + 1),
    localparam int CW = $clog2(CLR_SPAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          rx_bit,
    input  logic [ZW-1:0] zrun,
    output logic          los,
    output logic          change
);
    localparam logic [ZW-1:0] DECL_AT  = ZW'(DECL_LEN - 1);
    localparam logic [ZW-1:0] SHORT_AT = ZW'(CLR_RUN - 1);
    localparam logic [CW-1:0] SPAN_END = CW'(CLR_SPAN - 1);

    logic          zero_in;
    logic          hit_declare;
    logic          hit_short;
    logic [CW-1:0] wcnt;

    // Classify the incoming bit against both run thresholds.
    always_comb begin
        zero_in     = bit_en && !rx_bit;
        hit_declare = zero_in && (zrun >= DECL_AT);
        hit_short   = zero_in && (zrun >= SHORT_AT);
        change      = (!los && hit_declare) ||
                      (los && bit_en && !hit_short && (wcnt == SPAN_END));
    end

    // Toggle the alarm on a decided change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            los <= 1'b0;
        else if (change)
            los <= !los;
    end

    // Clearing window: counts clean bits while alarmed, restarts on a short run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt <= '0;
        else if (!los || hit_short || change)
            wcnt <= '0;
        else if (bit_en)
            wcnt <= wcnt + 1'b1;
    end

    p_declare_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!los && bit_en && !rx_bit && zrun == DECL_AT) |=> los);
    p_short_run_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (los && bit_en && !rx_bit && zrun >= SHORT_AT) |=> (los && wcnt == '0));
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(los));
endmodule

// File: rtl/los_event_flag.sv
// Module: sticky change flag, cleared by a host read, with a gated interrupt.
// Assumes change and rd_clr are single-cycle qualified strobes; set wins.
module los_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    input  logic rd_clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    // Latch changes; clear on read unless a change arrives at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (change)
            flag <= 1'b1;
        else if (rd_clr)
            flag <= 1'b0;
    end

    // Gate the flag onto the interrupt line.
    always_comb irq = flag && irq_en;

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> flag);
    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !change) |=> !flag);
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (change && rd_clr) |=> flag);
endmodule

// File: rtl/los_monitor.sv
// Top: line loss-of-signal monitor with change flag, interrupt and read port.
// Assumes a single host read strobe with a one-bit register select.
module los_monitor
    import los_pkg::*;
#(
    parameter int DECL_LEN = 32,
    parameter int CLR_SPAN = 32,
    parameter int CLR_RUN  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              irq_en,
    input  logic              rd_stb,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              los_irq
);
    localparam int ZW = $clog2(DECL_LEN + 1);

    logic [ZW-1:0] zrun;
    logic          los;
    logic          change;
    logic          flag;
    logic          rd_clr;
    reg_sel_e      sel;

    los_zero_run #(.RUN_SAT(DECL_LEN)) u_run (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .zrun(zrun)
    );

    los_alarm #(.DECL_LEN(DECL_LEN), .CLR_SPAN(CLR_SPAN), .CLR_RUN(CLR_RUN)) u_alarm (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .zrun(zrun), .los(los), .change(change)
    );

    los_event_flag u_flag (
        .clk(clk), .rst_n(rst_n), .change(change), .rd_clr(rd_clr),
        .irq_en(irq_en), .flag(flag), .irq(los_irq)
    );

    // Decode the select and the clearing read.
    always_comb begin
        sel    = reg_sel_e'(rd_sel);
        rd_clr = rd_stb && (sel == SEL_EVENT);
    end

    // Read mux: unused bits are zero.
    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_LIVE:  rd_data[LIVE_LOS_BIT]  = los;
            SEL_EVENT: rd_data[EVENT_CHG_BIT] = flag;
            default:   rd_data = '0;
        endcase
    end

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !los_irq);
endmodule

// File: tb/los_monitor_bench.sv
module los_monitor_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b1;
    logic       irq_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       los_irq;

    always #2 clk = ~clk;

    los_monitor u_los_monitor (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .irq_en(irq_en), .rd_stb(rd_stb), .rd_sel(rd_sel),
        .rd_data(rd_data), .los_irq(los_irq)
    );

    typedef struct {
        logic [7:0] data;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    // Reference model state, from the requirements.
    int   m_zrun = 0;
    int   m_win = 0;
    bit   m_los = 0;
    bit   m_flag = 0;

    task automatic cyc(input logic rn, input logic en, input logic b,
                       input logic rd, input logic sel, input logic ie,
                       input string tag);
        exp_t e;
        bit evt;
        @(negedge clk);
        rst_n = rn; bit_en = en; rx_bit = b; rd_stb = rd; rd_sel = sel; irq_en = ie;
        evt = 0;
        if (!rn) begin
            m_zrun = 0; m_win = 0; m_los = 0; m_flag = 0;
        end else begin
            if (en) begin
                m_zrun = b ? 0 : (m_zrun < 32 ? m_zrun + 1 : 32);
                if (!m_los) begin
                    if (m_zrun >= 32) begin m_los = 1; evt = 1; m_win = 0; end
                end else if (!b && m_zrun >= 4) begin
                    m_win = 0;
                end else if (m_win == 31) begin
                    m_los = 0; evt = 1; m_win = 0;
                end else begin
                    m_win = m_win + 1;
                end
            end
            if (evt) m_flag = 1;
            else if (rd && sel) m_flag = 0;
        end
        e.data = sel ? {6'b0, m_flag, 1'b0} : {1'b0, m_los, 6'b0};
        e.irq  = m_flag && ie;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic bits(input int n, input logic b, input logic sel,
                        input logic ie, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, b, 1'b0, sel, ie, tag);
    endtask

    // Monitor: compare each cycle's result just after the active edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (rd_data !== e.data || los_irq !== e.irq) begin
                    n_bad++;
                    $display("FAIL %s: data=%h irq=%b expected data=%h irq=%b",
                             e.tag, rd_data, los_irq, e.data, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1 reset live");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R1 reset event");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R1 reset live after");
        // R2: 31 zeros are not enough, 32 are.
        bits(31, 1'b0, 1'b0, 1'b0, "R2 below threshold");
        bits(1, 1'b1, 1'b0, 1'b0, "R2 run broken");
        bits(31, 1'b0, 1'b0, 1'b0, "R2 approaching");
        bits(1, 1'b0, 1'b0, 1'b0, "R2 declare R10 live bit");
        // R8: flag latched while masked, interrupt follows enable.
        bits(2, 1'b0, 1'b1, 1'b0, "R8 masked R5 rise flag");
        bits(2, 1'b0, 1'b1, 1'b1, "R8 irq enabled");
        // R6: live read does not clear, event read does.
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R6 live read");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R6 flag kept");
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R6 event read clears");
        // R4: a four-zero run restarts the clearing window.
        bits(20, 1'b1, 1'b0, 1'b1, "R4 partial window");
        bits(4, 1'b0, 1'b0, 1'b1, "R4 short run restart");
        // R3: 32 bits with runs of three zeros at most clear the alarm.
        for (int k = 0; k < 8; k++) begin
            bits(1, 1'b1, 1'b0, 1'b1, "R3 clean window");
            bits(3, 1'b0, 1'b0, 1'b1, "R3 clean window");
        end
        bits(2, 1'b1, 1'b1, 1'b1, "R5 fall flag");
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R6 clear after fall");
        // R9: disabled cycles do not count zeros.
        bits(20, 1'b0, 1'b0, 1'b1, "R9 zeros before gap");
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 gap ignored");
        bits(11, 1'b0, 1'b0, 1'b1, "R9 zeros after gap");
        // R7: declaring zero and clearing read on the same edge.
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R7 set wins");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R7 flag held");
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R7 alarm live");
        // R1: reset while alarmed.
        for (int i = 0; i < 2; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1 reset in alarm");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R1 flag after reset");
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R1 live after reset");
        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule